// File: doc/BRIEF.md
# Region to Page-Chunk Splitter

This block takes one mapping request (a virtual start address, a physical start address and a byte length) and cuts it into naturally aligned page chunks of 16MB, 1MB, 64KB or 4KB. It emits the chunks one at a time on a valid/ready output, so a downstream page-table writer can consume them at its own pace.

The request is first widened to whole 4KB granules. The offset of the virtual address inside its granule is added to the length, the low twelve bits of both addresses are dropped, and the length is rounded up to a granule multiple. The splitter then makes a greedy choice for each chunk. It takes the largest size that still fits in the remaining length and to which the current virtual address is aligned. The physical address plays no part in that choice. A single-cycle pulse marks the end of a request: `done` when the region is fully covered, or `err` when a chunk cannot be placed. A chunk cannot be placed when the walk has run past the top of the virtual address space.

Top module: `region_chunker`

## Requirements
- R1: After reset `chk_valid`, `done` and `err` are low and `req_ready` is high.
- R2: On acceptance the low 12 bits of the virtual address are added to the length. Those 12 bits are then cleared in both addresses, and the sum is rounded up to a multiple of 4096. Every emitted address therefore has its low 12 bits zero.
- R3: Each chunk takes the first size, in the order 16MB, 1MB, 64KB, 4KB, for which the remaining length is at least that size and the current virtual address is a multiple of it. The physical address has no effect on the choice.
- R4: `chk_size` encodes the chunk size as 0 = 4KB, 1 = 64KB, 2 = 1MB, 3 = 16MB. `chk_vaddr` is always a multiple of the encoded size.
- R5: After each accepted chunk, both addresses advance by the chunk size and the remaining length shrinks by it. Consecutive chunks are therefore contiguous in both address spaces.
- R6: While `chk_valid` is high and `chk_ready` is low, the chunk fields stay unchanged and `chk_valid` stays high.
- R7: `done` pulses high for one cycle in the cycle after the handshake of the last chunk.
- R8: A request whose rounded length is zero produces no chunk, and `done` is high in the cycle after acceptance.
- R9: If length remains but the virtual address has advanced past the top of the address space, no size qualifies. In that case no further chunk is emitted, `err` pulses in the following cycle and the block returns to idle. `done` and `err` are never high together.
- R10: `req_ready` is high only when no request is in progress. Request inputs presented while busy are ignored, and `chk_valid` and `req_ready` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_vaddr | input | AW | Virtual start address |
| req_paddr | input | AW | Physical start address |
| req_len | input | LW | Length in bytes |
| chk_valid | output | 1 | Chunk available |
| chk_ready | input | 1 | Downstream takes the chunk |
| chk_vaddr | output | AW | Chunk virtual address |
| chk_paddr | output | AW | Chunk physical address |
| chk_size | output | 2 | Chunk size code |
| done | output | 1 | Request fully covered (pulse) |
| err | output | 1 | Configuration error, request abandoned (pulse) |

## Verification
On every cycle, the assertions check four things:
- Chunks stay stable under back-pressure.
- Every chunk address is aligned to its size code and to 4KB.
- Successive chunks are contiguous.
- A chunk is never offered while a request could be accepted, and the two end pulses never coincide.

Only the bench's scenarios can show the rest, by comparing against a behavioural model on every clock:
- That the greedy choice picks the right size sequence.
- That the rounding of unaligned starts is right.
- That a misaligned physical address is ignored.
- The zero-length case.
- The wrap-around error.

// File: rtl/region_chunker.sv
module region_chunker #(
  parameter int AW = 32,
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  logic [AW-1:0] req_paddr,
  input  logic [LW-1:0] req_len,
  output logic          chk_valid,
  input  logic          chk_ready,
  output logic [AW-1:0] chk_vaddr,
  output logic [AW-1:0] chk_paddr,
  output logic [1:0]    chk_size,
  output logic          done,
  output logic          err
);
  localparam int RW = LW + 1;
  localparam logic [RW-1:0] GMASK = RW'(4095);

  logic          busy;
  logic [AW:0]   va_q;
  logic [AW-1:0] pa_q;
  logic [RW-1:0] rem_q;
  logic          done_q, err_q;
  logic          fit;
  logic [1:0]    code;

  wire [RW-1:0] adj     = RW'(req_len) + RW'(req_vaddr[11:0]);
  wire [RW-1:0] rounded = (adj + GMASK) & ~GMASK;
  wire [RW-1:0] bytes   = RW'(1) << (12 + 4 * int'(code));

  always_comb begin
    fit  = 1'b0;
    code = 2'd0;
    if (!va_q[AW]) begin
      if (rem_q >= (RW'(1) << 24) && va_q[23:0] == '0) begin
        fit = 1'b1; code = 2'd3;
      end else if (rem_q >= (RW'(1) << 20) && va_q[19:0] == '0) begin
        fit = 1'b1; code = 2'd2;
      end else if (rem_q >= (RW'(1) << 16) && va_q[15:0] == '0) begin
        fit = 1'b1; code = 2'd1;
      end else if (rem_q >= (RW'(1) << 12) && va_q[11:0] == '0) begin
        fit = 1'b1; code = 2'd0;
      end
    end
  end

  assign req_ready = !busy;
  assign chk_valid = busy && fit;
  assign chk_vaddr = va_q[AW-1:0];
  assign chk_paddr = pa_q;
  assign chk_size  = code;
  assign done      = done_q;
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      va_q   <= '0;
      pa_q   <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          va_q  <= {1'b0, req_vaddr & ~AW'(4095)};
          pa_q  <= req_paddr & ~AW'(4095);
          rem_q <= rounded;
          if (rounded == '0) done_q <= 1'b1;
          else               busy   <= 1'b1;
        end
      end else if (!fit) begin
        busy  <= 1'b0;
        err_q <= 1'b1;
      end else if (chk_ready) begin
        va_q  <= va_q + (AW+1)'(bytes);
        pa_q  <= pa_q + AW'(bytes);
        rem_q <= rem_q - bytes;
        if (rem_q == bytes) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/region_chunker_chk.sv
module region_chunker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          chk_valid,
  input logic          chk_ready,
  input logic [AW-1:0] chk_vaddr,
  input logic [AW-1:0] chk_paddr,
  input logic [1:0]    chk_size,
  input logic          done,
  input logic          err
);
  function automatic logic [AW-1:0] span(input logic [1:0] c);
    return AW'(1) << (12 + 4 * int'(c));
  endfunction

  a_r6_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !chk_ready |=> chk_valid && $stable(chk_vaddr) && $stable(chk_paddr) && $stable(chk_size));

  a_r4_vaddr_aligned_to_size: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> (chk_vaddr & (span(chk_size) - AW'(1))) == '0);

  a_r2_granule_addresses: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> chk_vaddr[11:0] == 12'd0 && chk_paddr[11:0] == 12'd0);

  a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_ready |=> !chk_valid ||
      (chk_vaddr == $past(chk_vaddr) + span($past(chk_size)) &&
       chk_paddr == $past(chk_paddr) + span($past(chk_size))));

  a_r10_no_chunk_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> !req_ready);

  a_r9_single_ending: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
endmodule

bind region_chunker region_chunker_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .chk_valid(chk_valid),
  .chk_ready(chk_ready), .chk_vaddr(chk_vaddr), .chk_paddr(chk_paddr),
  .chk_size(chk_size), .done(done), .err(err)
);

// File: tb/region_chunker_tb.sv
module region_chunker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_vaddr = '0, req_paddr = '0;
  logic [LW-1:0] req_len = '0;
  logic          chk_valid, chk_ready = 1'b0;
  logic [AW-1:0] chk_vaddr, chk_paddr;
  logic [1:0]    chk_size;
  logic          done, err;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_chunker #(.AW(AW), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_paddr(req_paddr), .req_len(req_len),
    .chk_valid(chk_valid), .chk_ready(chk_ready), .chk_vaddr(chk_vaddr),
    .chk_paddr(chk_paddr), .chk_size(chk_size), .done(done), .err(err)
  );

  logic [63:0] q_va[$];
  logic [63:0] q_pa[$];
  int          q_sz[$];
  logic        exp_err;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input logic [31:0] va, input logic [31:0] pa, input logic [31:0] len);
    logic [63:0] v, p, r, sz;
    int c;
    v = {32'd0, va} & ~64'hFFF;
    p = {32'd0, pa} & ~64'hFFF;
    r = ({32'd0, len} + {52'd0, va[11:0]} + 64'hFFF) & ~64'hFFF;
    exp_err = 1'b0;
    while (r != 0) begin
      if (v >= 64'h1_0000_0000) begin exp_err = 1'b1; break; end
      c = -1;
      for (int k = 3; k >= 0; k--) begin
        sz = 64'd1 << (12 + 4*k);
        if (c < 0 && r >= sz && (v & (sz - 1)) == 0) c = k;
      end
      sz = 64'd1 << (12 + 4*c);
      q_va.push_back(v); q_pa.push_back(p); q_sz.push_back(c);
      v = v + sz; p = (p + sz) & 64'hFFFF_FFFF; r = r - sz;
    end
  endtask

  // ready_mode: 0 always ready, 1 random; noise: keep req_valid high with junk while busy
  task automatic run(input logic [31:0] va, input logic [31:0] pa, input logic [31:0] len,
                     input int ready_mode, input bit noise, input string tag);
    int cyc;
    bit gap;
    build(va, pa, len);
    gap = exp_err;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_paddr = pa; req_len = len;
    @(negedge clk);
    if (noise) begin
      req_vaddr = 32'hDEAD_0000; req_paddr = 32'h0BAD_0000; req_len = 32'h0;
    end else req_valid = 1'b0;
    cyc = 0;
    forever begin
      cyc++;
      if (cyc > 20000) begin
        check(1'b0, {tag, " watchdog"}, 0, 1);
        break;
      end
      if (q_va.size() > 0) begin
        check(chk_valid === 1'b1, "R5 chunk valid", 64'(chk_valid), 1);
        check(chk_vaddr === q_va[0][31:0], "R3 chunk vaddr", 64'(chk_vaddr), q_va[0]);
        check(chk_paddr === q_pa[0][31:0], "R2 R5 chunk paddr", 64'(chk_paddr), q_pa[0]);
        check(chk_size === 2'(q_sz[0]), "R4 chunk size code", 64'(chk_size), 64'(q_sz[0]));
        check(!done && !err && !req_ready, "R10 busy flags", {61'd0, done, err, req_ready}, 0);
        chk_ready = (ready_mode == 0) ? 1'b1 : 1'($urandom_range(0, 1));
        if (chk_valid && chk_ready) begin
          q_va.pop_front(); q_pa.pop_front(); q_sz.pop_front();
        end
      end else if (gap) begin
        check(!chk_valid && !err && !done, "R9 no chunk before error", {62'd0, chk_valid, err}, 0);
        gap = 1'b0;
        chk_ready = 1'b0;
      end else begin
        check(chk_valid === 1'b0, "R7 R8 no chunk at end", 64'(chk_valid), 0);
        check(done === !exp_err, "R7 R8 done pulse", 64'(done), 64'(!exp_err));
        check(err === exp_err, "R9 error pulse", 64'(err), 64'(exp_err));
        req_valid = 1'b0;
        chk_ready = 1'b0;
        @(negedge clk);
        check(!done && !err && req_ready, "R7 single pulse, idle", {61'd0, done, err, req_ready}, 1);
        break;
      end
      @(negedge clk);
    end
    q_va.delete(); q_pa.delete(); q_sz.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!chk_valid && !done && !err && req_ready, "R1 reset state",
          {60'd0, chk_valid, done, err, req_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    run(32'h1000_0000, 32'h8000_0000, 32'h0110_0000, 0, 0, "R3 16M+1M");
    run(32'h0000_0800, 32'h1234_5678, 32'h0000_1000, 0, 0, "R2 unaligned start");
    run(32'h000F_0000, 32'h4000_0000, 32'h0031_0000, 1, 0, "R6 backpressure");
    run(32'h0100_0000, 32'h0000_3000, 32'h0100_0000, 0, 0, "R3 pa ignored");
    run(32'h0000_5000, 32'h0000_5000, 32'h0000_0000, 0, 0, "R8 zero length");
    run(32'hFFFF_E000, 32'h0000_0000, 32'h0000_4000, 0, 0, "R9 wrap error");
    run(32'h00FF_F123, 32'h2000_0000, 32'h0002_0000, 1, 1, "R10 ignored while busy");
    for (int i = 0; i < 20; i++)
      run($urandom, $urandom, $urandom_range(0, 32'h0030_0000), 1, i[0], "R3 random");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule